// File: doc/BRIEF.md
# Deep-Sleep Pad Isolation Controller

This block sets the output-enable and input-enable gates of a group of digital I/O pads across a deep-sleep episode. A mode bit is captured each time deep sleep is entered. With the mode clear, sleep changes nothing at the pads. With the mode set, the pads are isolated while asleep. Output drivers are switched off on every pad that is neither exempt nor a wakeup source. Input receivers are switched off on every pad that is not exempt.

Leaving sleep is staged. Receivers come back in the very cycle the wakeup strobe is seen. Drivers stay off until a release counter, loaded from a programmable count at the wakeup event, has run down to zero. Pads in the exemption mask are never gated. A sleep request that arrives while the counter runs is remembered and acted on after release.

Top module: `pad_sleep_iso`

## Requirements
- R1: After reset the controller is awake and every bit of `pad_oe_o` and `pad_ie_o` is 1.
- R2: If the captured mode is 0, every bit of `pad_oe_o` and `pad_ie_o` stays 1 through the whole sleep episode, including the release count.
- R3: While asleep with captured mode 1, `pad_oe_o[i]` is 0 unless `exempt_mask_i[i]` or `wake_src_mask_i[i]` is 1, in which case it is 1.
- R4: While asleep with captured mode 1, `pad_ie_o[i]` equals `exempt_mask_i[i]`.
- R5: A pad whose exemption bit is 1 has both enables at 1 in every cycle.
- R6: In the cycle where `wake_evt_i` is 1 while asleep, every bit of `pad_ie_o` is already 1, and it stays 1 afterwards.
- R7: `release_cnt_i` is captured in the wakeup cycle; calling it N, the output gating of R3 holds for N further cycles after the wakeup cycle and lifts in the cycle after those. With N = 0 the outputs are released in the cycle right after the wakeup cycle. Changes to `release_cnt_i` after the wakeup cycle have no effect.
- R8: `iso_mode_i` is sampled only at the clock edge where the controller leaves the awake state; changing it while asleep or counting has no effect on the current episode.
- R9: A `sleep_req_i` pulse during the release count does not cut the count short; after release the controller spends exactly one awake cycle and then enters sleep.
- R10: `wake_evt_i` while awake and `sleep_req_i` while asleep are ignored: the pad enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iso_mode_i | input | 1 | Isolation mode bit, captured at sleep entry |
| sleep_req_i | input | 1 | Deep-sleep entry strobe |
| wake_evt_i | input | 1 | Wakeup event strobe |
| release_cnt_i | input | CNT_W | Release count reload value |
| exempt_mask_i | input | NUM_PADS | Pads never gated |
| wake_src_mask_i | input | NUM_PADS | Pads whose drivers stay on while asleep |
| pad_oe_o | output | NUM_PADS | Per-pad output-enable gate |
| pad_ie_o | output | NUM_PADS | Per-pad input-enable gate |

## Verification
The bench sweeps every pairing of exemption and wakeup-source masks on a four-pad instance in both modes, so a design that let a wakeup-source mask reopen receivers, or gated an exempt pad, would show a wrong bit in some pairing. Release counts of zero and nonzero are counted cycle by cycle; a counter that is off by one releases the drivers a cycle early or late and is caught at the exact cycle. The mode and count inputs are flipped mid-episode, so a design that follows them live rather than capturing them changes the gating. A sleep request during counting catches a design that aborts the count or drops the request.

// File: rtl/pad_iso_pkg.sv
package pad_iso_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ASLEEP = 2'd1,
    ST_COUNT  = 2'd2
  } iso_state_t;

  // Driver gate: a pad keeps driving unless outputs are isolated and the pad
  // is neither exempt nor a wakeup source.
  function automatic logic oe_gate(input logic out_iso, input logic exempt,
                                   input logic wake_src);
    return !(out_iso && !exempt && !wake_src);
  endfunction

  // Receiver gate: only exemption keeps a receiver on under isolation.
  function automatic logic ie_gate(input logic in_iso, input logic exempt);
    return !(in_iso && !exempt);
  endfunction

endpackage

// File: rtl/pad_iso_timer.sv
module pad_iso_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (dec_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pad_iso_fsm.sv
module pad_iso_fsm
  import pad_iso_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iso_mode_i,
  input  logic       sleep_req_i,
  input  logic       wake_evt_i,
  input  logic       cnt_zero_i,
  output iso_state_t state_o,
  output logic       mode_o,
  output logic       enter_o,
  output logic       wake_o,
  output logic       release_o,
  output logic       pending_o
);
  iso_state_t state_q, state_d;
  logic       mode_q;
  logic       pend_q;

  assign enter_o   = (state_q == ST_AWAKE) && (sleep_req_i || pend_q);
  assign wake_o    = (state_q == ST_ASLEEP) && wake_evt_i;
  assign release_o = (state_q == ST_COUNT) && cnt_zero_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:  if (enter_o)   state_d = ST_ASLEEP;
      ST_ASLEEP: if (wake_o)    state_d = ST_COUNT;
      ST_COUNT:  if (release_o) state_d = ST_AWAKE;
      default:                  state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      mode_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter_o) mode_q <= iso_mode_i;
      if (enter_o)                                     pend_q <= 1'b0;
      else if ((state_q == ST_COUNT) && sleep_req_i)   pend_q <= 1'b1;
    end
  end

  assign state_o   = state_q;
  assign mode_o    = mode_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/pad_iso_gate.sv
module pad_iso_gate
  import pad_iso_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                out_iso_i,
  input  logic                in_iso_i,
  input  logic [NUM_PADS-1:0] exempt_i,
  input  logic [NUM_PADS-1:0] wake_src_i,
  output logic [NUM_PADS-1:0] oe_o,
  output logic [NUM_PADS-1:0] ie_o
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    assign oe_o[p] = oe_gate(out_iso_i, exempt_i[p], wake_src_i[p]);
    assign ie_o[p] = ie_gate(in_iso_i, exempt_i[p]);
  end
endmodule

// File: rtl/pad_sleep_iso.sv
module pad_sleep_iso
  import pad_iso_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iso_mode_i,
  input  logic                sleep_req_i,
  input  logic                wake_evt_i,
  input  logic [CNT_W-1:0]    release_cnt_i,
  input  logic [NUM_PADS-1:0] exempt_mask_i,
  input  logic [NUM_PADS-1:0] wake_src_mask_i,
  output logic [NUM_PADS-1:0] pad_oe_o,
  output logic [NUM_PADS-1:0] pad_ie_o
);
  iso_state_t       state;
  logic             mode_q;
  logic             enter_evt;
  logic             wake_seen;
  logic             release_evt;
  logic             pending;
  logic             cnt_zero;
  logic [CNT_W-1:0] cnt;
  logic             out_iso;
  logic             in_iso;

  pad_iso_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .iso_mode_i (iso_mode_i),
    .sleep_req_i(sleep_req_i),
    .wake_evt_i (wake_evt_i),
    .cnt_zero_i (cnt_zero),
    .state_o    (state),
    .mode_o     (mode_q),
    .enter_o    (enter_evt),
    .wake_o     (wake_seen),
    .release_o  (release_evt),
    .pending_o  (pending)
  );

  pad_iso_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (wake_seen),
    .load_val_i(release_cnt_i),
    .dec_i     (state == ST_COUNT),
    .cnt_o     (cnt),
    .zero_o    (cnt_zero)
  );

  // Receivers reopen combinationally on the wakeup strobe; drivers wait for
  // the counter.
  assign in_iso  = mode_q && (state == ST_ASLEEP) && !wake_evt_i;
  assign out_iso = mode_q && ((state == ST_ASLEEP) ||
                              ((state == ST_COUNT) && !cnt_zero));

  pad_iso_gate #(.NUM_PADS(NUM_PADS)) u_gate (
    .out_iso_i (out_iso),
    .in_iso_i  (in_iso),
    .exempt_i  (exempt_mask_i),
    .wake_src_i(wake_src_mask_i),
    .oe_o      (pad_oe_o),
    .ie_o      (pad_ie_o)
  );
endmodule

// File: rtl/pad_sleep_iso_chk.sv
module pad_sleep_iso_chk
  import pad_iso_pkg::*;
#(
  parameter int NUM_PADS = 8,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_req_i,
  input logic                wake_evt_i,
  input logic [NUM_PADS-1:0] exempt_mask_i,
  input logic [NUM_PADS-1:0] pad_oe_o,
  input logic [NUM_PADS-1:0] pad_ie_o,
  input iso_state_t          state,
  input logic                mode_q,
  input logic                release_evt,
  input logic [CNT_W-1:0]    cnt
);
  assert_exempt_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe_o & exempt_mask_i) == exempt_mask_i) &&
    ((pad_ie_o & exempt_mask_i) == exempt_mask_i));

  assert_mode0_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (&pad_oe_o && &pad_ie_o));

  assert_ie_on_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ASLEEP && wake_evt_i) |-> &pad_ie_o);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && cnt != '0) |=> (state == ST_COUNT && cnt == $past(cnt) - 1'b1));

  assert_release_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (state == ST_AWAKE && &pad_oe_o));

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_AWAKE) |=> $stable(mode_q));

  assert_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COUNT && sleep_req_i) |=> (state != ST_ASLEEP));

  assert_sleep_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ASLEEP && !wake_evt_i) |=> (state == ST_ASLEEP && $stable(pad_oe_o)) ||
                                            $changed(exempt_mask_i));

  assert_awake_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE && !sleep_req_i && wake_evt_i) |-> (&pad_oe_o && &pad_ie_o));
endmodule

bind pad_sleep_iso pad_sleep_iso_chk #(.NUM_PADS(NUM_PADS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req_i  (sleep_req_i),
  .wake_evt_i   (wake_evt_i),
  .exempt_mask_i(exempt_mask_i),
  .pad_oe_o     (pad_oe_o),
  .pad_ie_o     (pad_ie_o),
  .state        (state),
  .mode_q       (mode_q),
  .release_evt  (release_evt),
  .cnt          (cnt)
);

// File: tb/pad_sleep_iso_test.sv
module pad_sleep_iso_test;
  localparam int NP = 4;
  localparam int CW = 4;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iso_mode_i = 1'b0;
  logic          sleep_req_i = 1'b0;
  logic          wake_evt_i = 1'b0;
  logic [CW-1:0] release_cnt_i = '0;
  logic [NP-1:0] exempt_mask_i = '0;
  logic [NP-1:0] wake_src_mask_i = '0;
  logic [NP-1:0] pad_oe_o, pad_ie_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pad_sleep_iso #(.NUM_PADS(NP), .CNT_W(CW)) uut (.*);

  task automatic check(input string req, input logic [NP-1:0] act,
                       input logic [NP-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected enables while the gating is active: drivers on where exempt or
  // wake source, receivers on only where exempt.
  function automatic logic [NP-1:0] exp_oe(input bit gated, input bit m);
    return (gated && m) ? (exempt_mask_i | wake_src_mask_i) : ALL;
  endfunction
  function automatic logic [NP-1:0] exp_ie(input bit gated, input bit m);
    return (gated && m) ? exempt_mask_i : ALL;
  endfunction

  // One full episode: enter with mode m, wake with count n.
  task automatic episode(input bit m, input int n);
    @(negedge clk); sleep_req_i = 1'b1; iso_mode_i = m; wake_evt_i = 1'b1;
    #1 check("R10 wake while awake", pad_oe_o & pad_ie_o, ALL);
    @(negedge clk); sleep_req_i = 1'b0; wake_evt_i = 1'b0; iso_mode_i = ~m;
    #1 check(m ? "R3 oe asleep" : "R2 oe asleep", pad_oe_o, exp_oe(1, m));
    check(m ? "R4 ie asleep" : "R2 ie asleep", pad_ie_o, exp_ie(1, m));
    check("R5 exempt", pad_oe_o & pad_ie_o & exempt_mask_i, exempt_mask_i);
    @(negedge clk); sleep_req_i = 1'b1;
    #1 check("R8 R10 oe asleep", pad_oe_o, exp_oe(1, m));
    @(negedge clk); sleep_req_i = 1'b0; wake_evt_i = 1'b1; release_cnt_i = CW'(n);
    #1 check("R6 ie on wake", pad_ie_o, ALL);
    check("R7 oe on wake", pad_oe_o, exp_oe(1, m));
    @(negedge clk); wake_evt_i = 1'b0; release_cnt_i = ~CW'(n);
    for (int j = 1; j <= n + 1; j++) begin
      #1 check("R7 oe counting", pad_oe_o, exp_oe(j <= n, m));
      check("R6 ie counting", pad_ie_o, ALL);
      @(negedge clk);
    end
    #1 check("R7 oe awake", pad_oe_o & pad_ie_o, ALL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset oe", pad_oe_o, ALL);
    check("R1 reset ie", pad_ie_o, ALL);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 16; e++)
        for (int w = 0; w < 16; w++) begin
          exempt_mask_i = NP'(e); wake_src_mask_i = NP'(w);
          episode(m[0], (e + w + m) % 4);
        end
    // R9: sleep request during counting is deferred.
    exempt_mask_i = 4'b0001; wake_src_mask_i = 4'b0010;
    @(negedge clk); sleep_req_i = 1'b1; iso_mode_i = 1'b1;
    @(negedge clk); sleep_req_i = 1'b0;
    @(negedge clk); wake_evt_i = 1'b1; release_cnt_i = 4'd2;
    @(negedge clk); wake_evt_i = 1'b0; sleep_req_i = 1'b1;
    #1 check("R9 count 2", pad_oe_o, 4'b0011);
    @(negedge clk); sleep_req_i = 1'b0;
    #1 check("R9 count 1", pad_oe_o, 4'b0011);
    @(negedge clk);
    #1 check("R9 released", pad_oe_o, ALL);
    @(negedge clk);
    #1 check("R9 awake cycle", pad_oe_o, ALL);
    @(negedge clk);
    #1 check("R9 asleep again", pad_oe_o, 4'b0011);
    check("R9 ie asleep again", pad_ie_o, 4'b0001);
    @(negedge clk); wake_evt_i = 1'b1; release_cnt_i = 4'd0;
    @(negedge clk); wake_evt_i = 1'b0;
    #1 check("R7 zero count release", pad_oe_o, ALL);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule